// File: doc/BRIEF.md
# Peak-Hold Conversion Register

This block keeps the largest converter sample seen while free-running sampling is switched on. A new sample arrives with a one-cycle valid strobe and an 8-bit value. When automatic sampling is enabled, that value is compared with the peak held in the block. The held peak is replaced only when the new value is strictly greater.

Software reaches the peak through a register-style port at a single register address. On a read, the 8-bit peak sits left-aligned in bits 11:4 of a 16-bit word, and every other bit reads as zero. Writing an all-zero word clears the peak. Any other write loads bits 11:4 of the written word as the new peak. A write always takes precedence over a sample arriving in the same cycle.

Top module: `peak_hold_reg`

## Requirements
- R1: After synchronous reset, the register reads as 16'h0000.
- R2: While automatic mode is enabled, a strobed sample greater than the held peak becomes the held peak. The new value is visible on the read port one clock after the strobe.
- R3: A strobed sample equal to or smaller than the held peak leaves the peak unchanged.
- R4: While automatic mode is disabled, strobed samples never change the peak.
- R5: A write of 16'h0000 to the register address clears the peak to zero. This holds in either mode.
- R6: A nonzero write to the register address loads written bits 11:4 as the peak. Written bits 15:12 and 3:0 are ignored.
- R7: When a register write and a qualifying sample fall in the same cycle, the write decides the result and the sample is dropped.
- R8: Readback at the register address places the peak in bits 11:4, with bit 11 as its MSB. Bits 15:12 and 3:0 always read 0.
- R9: The register address is 8'h07. A write to any other address has no effect, and a read from any other address returns 16'h0000.
- R10: With the valid strobe low, the sample bus is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| auto_en | input | 1 | Automatic sampling mode enable; 0 = normal mode |
| smp_valid | input | 1 | One-cycle strobe marking a new sample |
| smp_data | input | 8 | Sample value |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 16 | Write word |
| rd_addr | input | 8 | Read address |
| rd_data | output | 16 | Read word (combinational from the held peak) |

## Verification
The bench builds the block with its default parameters: an 8-bit sample, the field starting at bit 4 of a 16-bit word, an 8-bit address, and register address 7. With these parameters all 256 sample codes can be swept in ascending order, so every step of strict growth is observed. Collisions between a write and a sample, reserved-bit writes, foreign addresses, and the equal-value case are all placed in a vector table that carries its own running expectation.

// File: rtl/peak_hold_pkg.sv
package peak_hold_pkg;

    // Default geometry of the held value inside the register word
    localparam int unsigned DEF_SAMPLE_W = 8;
    localparam int unsigned DEF_WORD_W   = 16;
    localparam int unsigned DEF_FIELD_LSB = 4;
    localparam int unsigned DEF_ADDR_W   = 8;
    localparam int unsigned DEF_REG_ADDR = 7;

    // Source selected for the next held value
    typedef enum logic [1:0] {
        SRC_HOLD   = 2'd0,
        SRC_SAMPLE = 2'd1,
        SRC_LOAD   = 2'd2,
        SRC_CLEAR  = 2'd3
    } upd_src_e;

endpackage

// File: rtl/peak_wr_decode.sv
module peak_wr_decode
    import peak_hold_pkg::*;
#(
    parameter int unsigned SAMPLE_W  = DEF_SAMPLE_W,
    parameter int unsigned WORD_W    = DEF_WORD_W,
    parameter int unsigned FIELD_LSB = DEF_FIELD_LSB,
    parameter int unsigned ADDR_W    = DEF_ADDR_W,
    parameter int unsigned REG_ADDR  = DEF_REG_ADDR
) (
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [WORD_W-1:0]   wr_data,
    output logic                wr_hit,
    output logic                wr_clear,
    output logic [SAMPLE_W-1:0] wr_field
);
    localparam int unsigned FIELD_MSB = FIELD_LSB + SAMPLE_W - 1;
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

    always_comb begin
        wr_hit   = wr_en && (wr_addr == MY_ADDR);
        wr_clear = wr_hit && (wr_data == '0);
        // reserved positions are dropped here
        wr_field = wr_data[FIELD_MSB:FIELD_LSB];
    end
endmodule

// File: rtl/peak_update_sel.sv
module peak_update_sel
    import peak_hold_pkg::*;
#(
    parameter int unsigned SAMPLE_W = DEF_SAMPLE_W
) (
    input  logic [SAMPLE_W-1:0] peak_q,
    input  logic                auto_en,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                wr_hit,
    input  logic                wr_clear,
    input  logic [SAMPLE_W-1:0] wr_field,
    output upd_src_e            src,
    output logic [SAMPLE_W-1:0] peak_d
);
    logic smp_wins;

    always_comb begin
        smp_wins = auto_en && smp_valid && (smp_data > peak_q);
        // priority: clear, then load, then sample, else hold
        if (wr_clear)       src = SRC_CLEAR;
        else if (wr_hit)    src = SRC_LOAD;
        else if (smp_wins)  src = SRC_SAMPLE;
        else                src = SRC_HOLD;

        unique case (src)
            SRC_CLEAR:  peak_d = '0;
            SRC_LOAD:   peak_d = wr_field;
            SRC_SAMPLE: peak_d = smp_data;
            default:    peak_d = peak_q;
        endcase
    end
endmodule

// File: rtl/peak_store.sv
module peak_store
    import peak_hold_pkg::*;
#(
    parameter int unsigned SAMPLE_W = DEF_SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  upd_src_e            src,
    input  logic [SAMPLE_W-1:0] peak_d,
    output logic [SAMPLE_W-1:0] peak_q
);
    always_ff @(posedge clk) begin
        if (rst)                 peak_q <= '0;
        else if (src != SRC_HOLD) peak_q <= peak_d;
    end

    // R1: reset leaves the held value at zero
    p_reset_zero_r1: assert property (@(posedge clk) rst |=> (peak_q == '0))
        else $error("p_reset_zero_r1");

    // R3: a hold cycle keeps the value
    p_hold_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_HOLD) |=> $stable(peak_q))
        else $error("p_hold_stable_r3");

    // R5: a clear cycle empties the register
    p_clear_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_CLEAR) |=> (peak_q == '0))
        else $error("p_clear_zero_r5");
endmodule

// File: rtl/peak_word_fmt.sv
module peak_word_fmt
    import peak_hold_pkg::*;
#(
    parameter int unsigned SAMPLE_W  = DEF_SAMPLE_W,
    parameter int unsigned WORD_W    = DEF_WORD_W,
    parameter int unsigned FIELD_LSB = DEF_FIELD_LSB,
    parameter int unsigned ADDR_W    = DEF_ADDR_W,
    parameter int unsigned REG_ADDR  = DEF_REG_ADDR
) (
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [SAMPLE_W-1:0] peak_q,
    output logic [WORD_W-1:0]   rd_data
);
    localparam int unsigned FIELD_MSB = FIELD_LSB + SAMPLE_W - 1;
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

    logic [WORD_W-1:0] word;

    always_comb begin
        word = '0;
        word[FIELD_MSB:FIELD_LSB] = peak_q;
        rd_data = (rd_addr == MY_ADDR) ? word : '0;
    end
endmodule

// File: rtl/peak_hold_reg.sv
module peak_hold_reg
    import peak_hold_pkg::*;
#(
    parameter int unsigned SAMPLE_W  = DEF_SAMPLE_W,
    parameter int unsigned WORD_W    = DEF_WORD_W,
    parameter int unsigned FIELD_LSB = DEF_FIELD_LSB,
    parameter int unsigned ADDR_W    = DEF_ADDR_W,
    parameter int unsigned REG_ADDR  = DEF_REG_ADDR
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                auto_en,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [WORD_W-1:0]   rd_data
);
    localparam int unsigned FIELD_MSB = FIELD_LSB + SAMPLE_W - 1;

    logic                wr_hit;
    logic                wr_clear;
    logic [SAMPLE_W-1:0] wr_field;
    logic [SAMPLE_W-1:0] peak_q;
    logic [SAMPLE_W-1:0] peak_d;
    upd_src_e            src;

    peak_wr_decode #(
        .SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W), .FIELD_LSB(FIELD_LSB),
        .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)
    ) u_dec (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_hit(wr_hit), .wr_clear(wr_clear), .wr_field(wr_field)
    );

    peak_update_sel #(.SAMPLE_W(SAMPLE_W)) u_sel (
        .peak_q(peak_q), .auto_en(auto_en), .smp_valid(smp_valid),
        .smp_data(smp_data), .wr_hit(wr_hit), .wr_clear(wr_clear),
        .wr_field(wr_field), .src(src), .peak_d(peak_d)
    );

    peak_store #(.SAMPLE_W(SAMPLE_W)) u_store (
        .clk(clk), .rst(rst), .src(src), .peak_d(peak_d), .peak_q(peak_q)
    );

    peak_word_fmt #(
        .SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W), .FIELD_LSB(FIELD_LSB),
        .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)
    ) u_fmt (
        .rd_addr(rd_addr), .peak_q(peak_q), .rd_data(rd_data)
    );

    // R2: a larger sample in automatic mode with no write becomes the peak
    p_sample_rise_r2: assert property (@(posedge clk) disable iff (rst)
        (auto_en && smp_valid && !wr_en && (smp_data > peak_q))
        |=> (peak_q == $past(smp_data)))
        else $error("p_sample_rise_r2");

    // R3: without a register write the peak never decreases
    p_no_decrease_r3: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (peak_q >= $past(peak_q)))
        else $error("p_no_decrease_r3");

    // R4: normal mode with no write keeps the peak
    p_normal_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!auto_en && !wr_en) |=> $stable(peak_q))
        else $error("p_normal_hold_r4");

    // R7: a register write overrides any same-cycle sample
    p_write_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr == ADDR_W'(REG_ADDR)))
        |=> (peak_q == $past(wr_data[FIELD_MSB:FIELD_LSB])))
        else $error("p_write_wins_r7");

    // R8: padding bits read as zero
    p_pad_zero_r8: assert property (@(posedge clk) disable iff (rst)
        ((rd_data & ~({{(WORD_W-SAMPLE_W){1'b0}}, {SAMPLE_W{1'b1}}} << FIELD_LSB)) == '0))
        else $error("p_pad_zero_r8");
endmodule

// File: tb/peak_hold_reg_tb_top.sv
module peak_hold_reg_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        auto_en = 1'b0;
    logic        smp_valid = 1'b0;
    logic [7:0]  smp_data = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  rd_addr = 8'h07;
    logic [15:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    peak_hold_reg dut_i (
        .clk(clk), .rst(rst), .auto_en(auto_en), .smp_valid(smp_valid),
        .smp_data(smp_data), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // Vector: {auto, valid, sample[8], wr, waddr[8], wdata[16], expected peak[8]}
    localparam int NV = 16;
    localparam logic [42:0] VEC [NV] = '{
        {1'b1, 1'b1, 8'h40, 1'b0, 8'h00, 16'h0000, 8'h40}, // R2 rise from zero
        {1'b1, 1'b1, 8'h30, 1'b0, 8'h00, 16'h0000, 8'h40}, // R3 smaller
        {1'b1, 1'b1, 8'h40, 1'b0, 8'h00, 16'h0000, 8'h40}, // R3 equal
        {1'b0, 1'b1, 8'h90, 1'b0, 8'h00, 16'h0000, 8'h40}, // R4 normal mode
        {1'b1, 1'b0, 8'hF0, 1'b0, 8'h00, 16'h0000, 8'h40}, // R10 no strobe
        {1'b1, 1'b1, 8'h41, 1'b0, 8'h00, 16'h0000, 8'h41}, // R2 by one
        {1'b0, 1'b0, 8'h00, 1'b1, 8'h07, 16'h0000, 8'h00}, // R5 clear
        {1'b1, 1'b1, 8'h05, 1'b0, 8'h00, 16'h0000, 8'h05}, // R2 after clear
        {1'b0, 1'b0, 8'h00, 1'b1, 8'h07, 16'hFA5F, 8'hA5}, // R6 reserved ignored
        {1'b1, 1'b1, 8'hC0, 1'b1, 8'h07, 16'h0000, 8'h00}, // R7 clear beats sample
        {1'b1, 1'b1, 8'h80, 1'b0, 8'h00, 16'h0000, 8'h80}, // R2
        {1'b1, 1'b1, 8'hFF, 1'b1, 8'h07, 16'h0120, 8'h12}, // R7 load beats sample
        {1'b1, 1'b0, 8'h00, 1'b1, 8'h06, 16'h0000, 8'h12}, // R9 foreign address
        {1'b0, 1'b1, 8'hFF, 1'b1, 8'h07, 16'h0000, 8'h00}, // R5 clear in normal mode
        {1'b1, 1'b1, 8'hFF, 1'b0, 8'h00, 16'h0000, 8'hFF}, // R2 full scale
        {1'b1, 1'b1, 8'hFE, 1'b0, 8'h00, 16'h0000, 8'hFF}  // R3 below full scale
    };
    localparam int VREQ [NV] = '{2, 3, 3, 4, 10, 2, 5, 2, 6, 7, 2, 7, 9, 5, 2, 3};

    task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        auto_en = 1'b0; smp_valid = 1'b0; smp_data = '0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        // reset
        repeat (3) step();
        rst = 1'b0;
        step();
        check(1, rd_data, 16'h0000); // R1 reset value

        // vector table
        for (int i = 0; i < NV; i++) begin
            auto_en   = VEC[i][42];
            smp_valid = VEC[i][41];
            smp_data  = VEC[i][40:33];
            wr_en     = VEC[i][32];
            wr_addr   = VEC[i][31:24];
            wr_data   = VEC[i][23:8];
            step();
            idle_inputs();
            check(VREQ[i], rd_data, {4'h0, VEC[i][7:0], 4'h0}); // R8 layout
        end

        // R9: read from another address returns zero
        rd_addr = 8'h06;
        #1 check(9, rd_data, 16'h0000);
        rd_addr = 8'h07;

        // R2: ascending sweep over all sample codes
        wr_en = 1'b1; wr_addr = 8'h07; wr_data = 16'h0000;
        step();
        idle_inputs();
        for (int v = 1; v < 256; v++) begin
            auto_en = 1'b1; smp_valid = 1'b1; smp_data = 8'(v);
            step();
            idle_inputs();
            check(2, rd_data, {4'h0, 8'(v), 4'h0});
        end

        // R6: write with only reserved bits set loads zero field
        wr_en = 1'b1; wr_addr = 8'h07; wr_data = 16'hF00F;
        step();
        idle_inputs();
        check(6, rd_data, 16'h0000);

        // R1: reset in mid-run
        wr_en = 1'b1; wr_addr = 8'h07; wr_data = 16'h0770;
        step();
        idle_inputs();
        check(6, rd_data, 16'h0770);
        rst = 1'b1;
        step();
        rst = 1'b0;
        check(1, rd_data, 16'h0000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule